// File: doc/BRIEF.md
# Read-Triggered Processor Sleep-Level Controller

This block puts the processor into a deeper sleep level when software reads one of three level registers in I/O space. The read itself does the work. The register always returns zero, and writing to it does nothing. The three registers sit at fixed offsets above a programmable base address. Two I/O requesters can access the block in the same cycle, so conflicting requests are resolved by a fixed priority that always picks the shallowest requested level.

After a qualifying read, the controller holds the requested state and keeps the active-low stop-clock output asserted. It stays there until a break event is sampled, and returns to the running state one cycle later. A configuration input changes level-3 reads into level-4 entry. Throttle requests pass through only while the processor is running. In any sleep state they are suppressed, including the level-2 state, where throttling must be ignored.

Top module: `cstate_ctl`

## Requirements
- R1: After reset the state output is 00 (running) and the stop-clock output is high.
- R2: An access decodes only at base+14h, base+15h and base+16h. The hit flag of a port is high in a cycle when that port reads or writes one of those three addresses, and low otherwise. An access at any other address changes no state.
- R3: The read data of every port is 00h at all times, including reads of the level registers.
- R4: A read at base+14h while running sets the state to 01 (C2) on the next clock edge.
- R5: A read at base+15h while running sets the state to 10 (C3). A read at base+16h sets it to 11 (C4).
- R6: While the level-4-for-level-3 input is high, a read at base+15h while running sets the state to 11.
- R7: When several level reads arrive in the same cycle, the shallowest level wins. Base+14h beats base+15h and base+16h, and base+15h beats base+16h.
- R8: Writes to the level registers leave the state unchanged.
- R9: A sleep state (01, 10 or 11) holds for as long as no break event is sampled. Level reads in that time are ignored.
- R10: A break event sampled in a sleep state returns the state to 00 on the next clock edge.
- R11: The throttle output follows the throttle request only in state 00. In every sleep state it is low.
- R12: The stop-clock output is low in exactly the cycles where the state is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_base | input | AW | Base address of the register block |
| io_addr | input | NP*AW | I/O address, one per port |
| io_rd | input | NP | Read strobe, one per port |
| io_wr | input | NP | Write strobe, one per port |
| io_rdata | output | NP*8 | Read data, one byte per port (always 00h) |
| io_hit | output | NP | Address-decode hit, one per port |
| c4_for_c3 | input | 1 | When high, base+15h reads enter C4 instead of C3 |
| brk_evt | input | 1 | Break event that ends a sleep state |
| thr_req | input | 1 | Throttle request |
| thr_out | output | 1 | Throttle request passed to the clock logic |
| stpclk_n | output | 1 | Active-low stop-clock |
| cstate | output | 2 | Current state: 00 C0, 01 C2, 10 C3, 11 C4 |

## Verification
The assertions watch the following on every cycle:
- the stop-clock output matches the state;
- a sleep state holds until a break event, and a break event wakes the processor on the next cycle;
- a level-2 read from the running state always lands in C2, and a level-3 read with the level-4 option set lands in C4;
- no throttle request leaks out during sleep;
- the state never moves without a level read.

Only the bench scenarios show the full set of priority outcomes for two simultaneous requesters. They also show that writes and near-miss addresses (base+13h, base+17h) are ignored, that reads made during sleep cannot change the level, and that the exact cycle of each transition is correct.

// File: rtl/cstate_ctl.sv
module cstate_ctl #(
  parameter int AW = 16,
  parameter int NP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        pm_base,
  input  logic [NP-1:0][AW-1:0] io_addr,
  input  logic [NP-1:0]        io_rd,
  input  logic [NP-1:0]        io_wr,
  output logic [NP-1:0][7:0]   io_rdata,
  output logic [NP-1:0]        io_hit,
  input  logic                 c4_for_c3,
  input  logic                 brk_evt,
  input  logic                 thr_req,
  output logic                 thr_out,
  output logic                 stpclk_n,
  output logic [1:0]           cstate
);

  typedef enum logic [1:0] {S_RUN = 2'b00, S_L2 = 2'b01, S_L3 = 2'b10, S_L4 = 2'b11} lvl_t;

  localparam logic [AW-1:0] OFS_L2 = AW'(8'h14);
  localparam logic [AW-1:0] OFS_L3 = AW'(8'h15);
  localparam logic [AW-1:0] OFS_L4 = AW'(8'h16);

  logic [AW-1:0] a_l2, a_l3, a_l4;
  logic [NP-1:0] rq2, rq3, rq4;
  lvl_t st, st_nx;

  assign a_l2 = pm_base + OFS_L2;
  assign a_l3 = pm_base + OFS_L3;
  assign a_l4 = pm_base + OFS_L4;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic m2, m3, m4;
    assign m2 = io_addr[p] == a_l2;
    assign m3 = io_addr[p] == a_l3;
    assign m4 = io_addr[p] == a_l4;
    assign io_hit[p]   = (io_rd[p] | io_wr[p]) & (m2 | m3 | m4);
    assign io_rdata[p] = 8'h00;
    assign rq2[p] = io_rd[p] & m2;
    assign rq3[p] = io_rd[p] & m3;
    assign rq4[p] = io_rd[p] & m4;
  end

  always_comb begin
    st_nx = st;
    if (st == S_RUN) begin
      if (|rq2)      st_nx = S_L2;
      else if (|rq3) st_nx = c4_for_c3 ? S_L4 : S_L3;
      else if (|rq4) st_nx = S_L4;
    end else if (brk_evt) begin
      st_nx = S_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_RUN;
    else        st <= st_nx;
  end

  assign cstate   = st;
  assign stpclk_n = (st == S_RUN);
  assign thr_out  = thr_req & (st == S_RUN);

endmodule

// File: rtl/cstate_ctl_chk.sv
module cstate_ctl_chk #(
  parameter int AW = 16,
  parameter int NP = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [AW-1:0]         pm_base,
  input logic [NP-1:0][AW-1:0] io_addr,
  input logic [NP-1:0]         io_rd,
  input logic [NP-1:0]         io_wr,
  input logic [NP-1:0][7:0]    io_rdata,
  input logic [NP-1:0]         io_hit,
  input logic                  c4_for_c3,
  input logic                  brk_evt,
  input logic                  thr_req,
  input logic                  thr_out,
  input logic                  stpclk_n,
  input logic [1:0]            cstate
);

  logic l2, l3, l4;
  always_comb begin
    l2 = 1'b0; l3 = 1'b0; l4 = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (io_rd[p] && io_addr[p] == pm_base + AW'(8'h14)) l2 = 1'b1;
      if (io_rd[p] && io_addr[p] == pm_base + AW'(8'h15)) l3 = 1'b1;
      if (io_rd[p] && io_addr[p] == pm_base + AW'(8'h16)) l4 = 1'b1;
    end
  end

  assert_stpclk_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stpclk_n == (cstate == 2'b00));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate != 2'b00 && !brk_evt) |=> $stable(cstate));
  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate != 2'b00 && brk_evt) |=> cstate == 2'b00);
  assert_enter_c2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate == 2'b00 && l2) |=> cstate == 2'b01);
  assert_c4_for_c3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate == 2'b00 && l3 && !l2 && c4_for_c3) |=> cstate == 2'b11);
  assert_no_throttle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cstate != 2'b00 |-> !thr_out);
  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate == 2'b00 && !l2 && !l3 && !l4) |=> cstate == 2'b00);

endmodule

bind cstate_ctl cstate_ctl_chk #(.AW(AW), .NP(NP)) u_chk (.*);

// File: tb/sim_cstate_ctl.sv
`timescale 1ns/1ps
module sim_cstate_ctl;
  localparam int AW = 16;
  localparam int NP = 2;
  localparam logic [AW-1:0] BASE = 16'h0400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] pm_base = BASE;
  logic [NP-1:0][AW-1:0] io_addr = '0;
  logic [NP-1:0] io_rd = '0, io_wr = '0;
  logic [NP-1:0][7:0] io_rdata;
  logic [NP-1:0] io_hit;
  logic c4_for_c3 = 1'b0, brk_evt = 1'b0, thr_req = 1'b0;
  logic thr_out, stpclk_n;
  logic [1:0] cstate;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cstate_ctl #(.AW(AW), .NP(NP)) u0 (.*);

  // {ofs0, rd0, wr0, ofs1, rd1, wr1, c4_for_c3, expected state}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {8'h14, 2'b10, 8'h00, 2'b00, 1'b0, 2'b01},  // R4
    {8'h15, 2'b10, 8'h00, 2'b00, 1'b0, 2'b10},  // R5
    {8'h16, 2'b10, 8'h00, 2'b00, 1'b0, 2'b11},  // R5
    {8'h15, 2'b10, 8'h00, 2'b00, 1'b1, 2'b11},  // R6
    {8'h14, 2'b01, 8'h00, 2'b00, 1'b0, 2'b00},  // R8
    {8'h14, 2'b10, 8'h15, 2'b10, 1'b0, 2'b01},  // R7
    {8'h16, 2'b10, 8'h14, 2'b10, 1'b0, 2'b01},  // R7
    {8'h15, 2'b10, 8'h16, 2'b10, 1'b0, 2'b10},  // R7
    {8'h16, 2'b10, 8'h15, 2'b10, 1'b1, 2'b11},  // R6 with R7
    {8'h17, 2'b10, 8'h00, 2'b00, 1'b0, 2'b00},  // R2
    {8'h13, 2'b10, 8'h13, 2'b01, 1'b0, 2'b00},  // R2
    {8'h16, 2'b01, 8'h15, 2'b01, 1'b0, 2'b00},  // R8
    {8'h10, 2'b10, 8'h14, 2'b10, 1'b0, 2'b01}   // R4 on second port
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic dec(input logic [7:0] o);
    return o == 8'h14 || o == 8'h15 || o == 8'h16;
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 state", 32'(cstate), 0);
    chk("R1 stpclk", 32'(stpclk_n), 1);
    rst_n = 1'b1;
    step();
    chk("R1 state after release", 32'(cstate), 0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] o0, o1;
      logic [1:0] e;
      o0 = VEC[i][22:15]; o1 = VEC[i][12:5]; e = VEC[i][1:0];
      io_addr[0] = BASE + AW'(o0); io_rd[0] = VEC[i][14]; io_wr[0] = VEC[i][13];
      io_addr[1] = BASE + AW'(o1); io_rd[1] = VEC[i][4];  io_wr[1] = VEC[i][3];
      c4_for_c3 = VEC[i][2];
      #1;
      chk("R2 hit0", 32'(io_hit[0]), 32'((VEC[i][14] | VEC[i][13]) & dec(o0)));
      chk("R2 hit1", 32'(io_hit[1]), 32'((VEC[i][4] | VEC[i][3]) & dec(o1)));
      chk("R3 rdata", 32'(io_rdata), 0);
      step();
      io_rd = '0; io_wr = '0; c4_for_c3 = 1'b0;
      chk($sformatf("R4-R8 vector %0d state", i), 32'(cstate), 32'(e));
      chk("R12 stpclk", 32'(stpclk_n), 32'(e == 2'b00));
      if (e != 2'b00) begin
        brk_evt = 1'b1; step(); brk_evt = 1'b0;
        chk("R10 wake", 32'(cstate), 0);
        chk("R10 stpclk released", 32'(stpclk_n), 1);
      end
    end

    // R9: hold in C3, reads during sleep ignored
    io_addr[0] = BASE + 16'h15; io_rd[0] = 1'b1; step(); io_rd = '0;
    chk("R9 enter C3", 32'(cstate), 2);
    io_addr[0] = BASE + 16'h14; io_rd[0] = 1'b1;
    io_addr[1] = BASE + 16'h16; io_rd[1] = 1'b1;
    step(); io_rd = '0;
    for (int k = 0; k < 5; k++) step();
    chk("R9 hold C3", 32'(cstate), 2);
    chk("R12 stpclk in C3", 32'(stpclk_n), 0);

    // R11: throttle suppressed in sleep, passes in C0
    thr_req = 1'b1; #1;
    chk("R11 throttle in C3", 32'(thr_out), 0);
    brk_evt = 1'b1; step(); brk_evt = 1'b0;
    chk("R10 wake from C3", 32'(cstate), 0);
    chk("R11 throttle in C0", 32'(thr_out), 1);
    io_addr[0] = BASE + 16'h14; io_rd[0] = 1'b1; step(); io_rd = '0;
    chk("R4 enter C2", 32'(cstate), 1);
    chk("R11 throttle in C2", 32'(thr_out), 0);
    thr_req = 1'b0;

    // R1: reset from sleep
    rst_n = 1'b0; step();
    chk("R1 reset from C2", 32'(cstate), 0);
    chk("R1 stpclk after reset", 32'(stpclk_n), 1);
    rst_n = 1'b1; step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule